// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter (slave timing)

This block turns pairs of 24-bit two's-complement audio samples into a one-wire serial stream. An external master supplies the bit clock and the word (frame) clock, and the block follows both. Both clocks are oversampled by the block's own system clock through two-stage synchronizers. On every detected falling edge of the bit clock, the block presents the next bit on its serial output. The receiver can then sample on the rising edge.

A static format input selects one of two framings:
- **Left-justified:** the most significant bit follows the word-clock change immediately.
- **Delayed-by-one:** the common inter-IC sound framing, where the MSB comes one bit clock later.

The block counts bit-clock cycles in every frame. When a frame has exactly 32 cycles, each channel slot carries only the upper 16 bits of the sample. Any other count gives the full 24 bits. All slot positions after the last data bit are driven low.

Samples arrive on a parallel port with a valid strobe and are held in a pending pair. At the start of each left slot, the whole pair is copied into the working registers. A frame therefore always carries the left and right samples of one pair.

Top module: `stereo_serial_tx`

## Requirements
- R1: With `fmt_sel` = 0 (left-justified), the left channel occupies the slot while `word_clk` is 1 and the right channel the slot while it is 0. The sample MSB is output on the first falling `bit_clk` edge of the slot, which is the edge at which `word_clk` changes.
- R2: With `fmt_sel` = 1 (delayed framing), the left channel occupies the slot while `word_clk` is 0 and the right channel the slot while it is 1. The MSB is output on the second falling edge of the slot. The first falling edge of a slot carries the previous slot's bit at that position: that bit's data bit, or 0 if the position is padding.
- R3: Samples go out MSB first, bit 23 down. `ser_out` changes only in the system-clock cycle after a detected falling edge of `bit_clk`.
- R4: If the previous frame held any count of falling `bit_clk` edges other than 32 (for example 48, 64 or 128), a slot carries all 24 sample bits.
- R5: If the previous frame held exactly 32 falling `bit_clk` edges, a slot carries sample bits 23 down to 8 only (16 bits).
- R6: Every slot position after the last transmitted data bit outputs 0 until the next `word_clk` change.
- R7: A sample pair presented with `smp_valid` = 1 is held as pending; a later strobe overwrites it. At the first edge of a left slot, both pending words are copied together. A strobe during a frame therefore affects only the following frame.
- R8: A frame runs from one left-slot start to the next. Its edge count is measured on every frame, and the resulting word length applies from the next left-slot start on. The first frame after reset always uses 24 bits.
- R9: After reset, the pending and working samples are zero and `ser_out` is 0, and `ser_out` stays 0 until the first left slot starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `bit_clk` |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 1 | Framing select: 0 left-justified, 1 delayed-by-one |
| bit_clk | input | 1 | Serial bit clock from the master |
| word_clk | input | 1 | Frame clock from the master, one period per stereo pair |
| smp_valid | input | 1 | Strobe: load `smp_left` and `smp_right` as the pending pair |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| ser_out | output | 1 | Serial data, updated after falling `bit_clk` edges |

## Verification
The bound checker watches the following on every cycle:
- that the output moves only after a falling bit-clock edge;
- that the working pair changes only at a left-slot start, and then to exactly the pending pair;
- that the word-length choice changes only at a frame start and is never short before a frame has been measured;
- that the output stays low until the first left slot.

Only the bench's scenarios can show the rest:
- the bit order and slot alignment of each framing;
- the one-cycle carry of the previous slot's last bit in delayed framing;
- zero padding;
- the one-frame lag of the 16/24-bit switch when the frame length changes in the middle of a run.

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx #(
  parameter int SAMPLE_W    = 24,
  parameter int SHORT_W     = 16,
  parameter int SHORT_FRAME = 32,
  parameter int CNT_W       = 8,
  parameter int FCNT_W      = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt_sel,
  input  logic                bit_clk,
  input  logic                word_clk,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                ser_out
);

  localparam logic [CNT_W-1:0]  LONG_LEN  = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0]  SHORT_LEN = CNT_W'(SHORT_W);
  localparam logic [FCNT_W-1:0] SHORT_CNT = FCNT_W'(SHORT_FRAME);

  logic [2:0] bclk_sh;
  logic [1:0] wclk_sh;
  logic       lr, lr_prev;
  logic [CNT_W-1:0]  cnt;
  logic [FCNT_W-1:0] fcnt;
  logic       armed, short_mode;
  logic [SAMPLE_W-1:0] pend_l, pend_r, cur_l, cur_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_sh <= '0;
      wclk_sh <= '0;
    end else begin
      bclk_sh <= {bclk_sh[1:0], bit_clk};
      wclk_sh <= {wclk_sh[0], word_clk};
    end
  end

  logic sclk_fall, edge_lr, is_left, prev_left, frame_start, short_next;
  logic [CNT_W-1:0] cnt_nxt;

  assign sclk_fall   = bclk_sh[2] & ~bclk_sh[1];
  assign lr          = wclk_sh[1];
  assign edge_lr     = lr ^ lr_prev;
  assign is_left     = lr ^ fmt_sel;
  assign prev_left   = lr_prev ^ fmt_sel;
  assign frame_start = edge_lr & is_left;
  assign short_next  = (frame_start & armed) ? (fcnt == SHORT_CNT) : short_mode;
  assign cnt_nxt     = edge_lr ? '0 : ((cnt == '1) ? cnt : cnt + 1'b1);

  logic                carry;
  logic [CNT_W-1:0]    sel_p, sel_w;
  logic [SAMPLE_W-1:0] sel_word, shifted;
  logic                bit_val;

  assign carry = edge_lr & fmt_sel;

  always_comb begin
    if (carry) begin
      sel_p    = cnt;
      sel_word = prev_left ? cur_l : cur_r;
      sel_w    = short_mode ? SHORT_LEN : LONG_LEN;
    end else begin
      sel_p    = cnt_nxt - {{(CNT_W-1){1'b0}}, fmt_sel};
      sel_word = frame_start ? pend_l : (is_left ? cur_l : cur_r);
      sel_w    = short_next ? SHORT_LEN : LONG_LEN;
    end
  end

  assign shifted = sel_word << sel_p;
  assign bit_val = (sel_p < sel_w) & shifted[SAMPLE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_l <= '0;
      pend_r <= '0;
    end else if (smp_valid) begin
      pend_l <= smp_left;
      pend_r <= smp_right;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_prev    <= 1'b0;
      cnt        <= '0;
      fcnt       <= '0;
      armed      <= 1'b0;
      short_mode <= 1'b0;
      cur_l      <= '0;
      cur_r      <= '0;
      ser_out    <= 1'b0;
    end else if (sclk_fall) begin
      lr_prev <= lr;
      cnt     <= cnt_nxt;
      ser_out <= bit_val;
      if (frame_start) begin
        fcnt       <= FCNT_W'(1);
        armed      <= 1'b1;
        short_mode <= short_next;
        cur_l      <= pend_l;
        cur_r      <= pend_r;
      end else if (fcnt != '1) begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

endmodule

module stereo_serial_tx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sclk_fall,
  input logic                frame_start,
  input logic                armed,
  input logic                short_mode,
  input logic                ser_out,
  input logic [SAMPLE_W-1:0] pend_l,
  input logic [SAMPLE_W-1:0] pend_r,
  input logic [SAMPLE_W-1:0] cur_l,
  input logic [SAMPLE_W-1:0] cur_r
);

  p_shift_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(ser_out));

  p_pair_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && frame_start) |=> (cur_l == $past(pend_l) && cur_r == $past(pend_r)));

  p_pair_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_fall && frame_start) |=> ($stable(cur_l) && $stable(cur_r)));

  p_len_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_fall && frame_start) |=> $stable(short_mode));

  p_len_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    short_mode |-> armed);

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !ser_out);

endmodule

bind stereo_serial_tx stereo_serial_tx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .frame_start(frame_start),
  .armed(armed), .short_mode(short_mode), .ser_out(ser_out),
  .pend_l(pend_l), .pend_r(pend_r), .cur_l(cur_l), .cur_r(cur_r)
);

// File: tb/stereo_serial_tx_test.sv
module stereo_serial_tx_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 5;
  localparam int PRE   = 4;
  localparam int WDOG  = 150000;

  logic clk = 1'b0;
  logic rst_n, fmt_sel, bit_clk, word_clk, smp_valid, ser_out;
  logic [23:0] smp_left, smp_right;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  int frame_len [0:7];

  always #(CLK_P/2) clk = ~clk;

  stereo_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bit_clk(bit_clk),
    .word_clk(word_clk), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .ser_out(ser_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WDOG) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitcyc(input logic lv, output logic b);
    bit_clk  = 1'b0;
    word_clk = lv;
    tick(HALF);
    b = ser_out;
    bit_clk = 1'b1;
    tick(HALF);
  endtask

  function automatic logic [23:0] pat(input int s, input int j, input bit right);
    logic [23:0] v;
    v = 24'(s * 24'h0003A5 + j * 24'h1F2D3B + 24'h800123);
    return right ? (v ^ 24'h96C35A) : (v ^ 24'h5A3C69);
  endfunction

  function automatic logic [63:0] exp_slot(input bit f, input int n, input logic [23:0] word,
                                           input int w, input logic [23:0] pw, input int pn,
                                           input int pww);
    logic [63:0] e;
    e = '0;
    for (int k = 0; k < n; k++) begin
      if (!f) e[k] = (k < w) ? word[23-k] : 1'b0;
      else if (k == 0) e[k] = (pn - 1 < pww) ? pw[24-pn] : 1'b0;
      else e[k] = (k - 1 < w) ? word[24-k] : 1'b0;
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] ex);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s got=%h exp=%h", tag, got, ex);
    end
  endtask

  // R1 R2 R3 R4 R5 R6 R7 R8 are all checked per slot; R9 at reset and in the preamble.
  task automatic run(input int s, input bit f, input int nfr);
    logic b;
    logic [63:0] got, ex;
    logic [23:0] pw;
    int pn, pww, half, w;
    string tag;
    rst_n = 1'b0; fmt_sel = f; bit_clk = 1'b1; word_clk = f; smp_valid = 1'b0;
    smp_left = '0; smp_right = '0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    check(ser_out == 1'b0, "R9 reset output", {63'd0, ser_out}, 64'd0);
    smp_left = pat(s, 0, 0); smp_right = pat(s, 0, 1); smp_valid = 1'b1;
    tick(1);
    smp_valid = 1'b0;
    got = '0;
    for (int k = 0; k < PRE; k++) begin
      bitcyc(f, b);
      got[k] = b;
    end
    check(got == 64'd0, "R9 preamble low", got, 64'd0);
    pw = '0; pn = PRE; pww = 24;
    for (int j = 0; j < nfr; j++) begin
      half = frame_len[j] / 2;
      w = (j > 0 && frame_len[j-1] == 32) ? 16 : 24;
      tag = $sformatf("%s %s R3 R6 R7 R8 scen=%0d frame=%0d", f ? "R2" : "R1",
                      (w == 16) ? "R5" : "R4", s, j);
      got = '0;
      for (int k = 0; k < half; k++) begin
        if (k == half / 2) begin
          smp_left = pat(s, j, 0) ^ 24'hFFFFFF; smp_right = pat(s, j, 1) ^ 24'hFFFFFF;
          smp_valid = 1'b1;
        end
        bitcyc(!f, b);
        smp_valid = 1'b0;
        got[k] = b;
      end
      ex = exp_slot(f, half, pat(s, j, 0), w, pw, pn, pww);
      check(got == ex, {tag, " left"}, got, ex);
      got = '0;
      for (int k = 0; k < half; k++) begin
        if (k == 1) begin
          smp_left = pat(s, j + 1, 0); smp_right = pat(s, j + 1, 1); smp_valid = 1'b1;
        end
        bitcyc(f, b);
        smp_valid = 1'b0;
        got[k] = b;
      end
      ex = exp_slot(f, half, pat(s, j, 1), w, pat(s, j, 0), half, w);
      check(got == ex, {tag, " right"}, got, ex);
      pw = pat(s, j, 1); pn = half; pww = w;
    end
  endtask

  task automatic set_len(input int a, input int b, input int c, input int d, input int e);
    frame_len[0] = a; frame_len[1] = b; frame_len[2] = c; frame_len[3] = d; frame_len[4] = e;
  endtask

  initial begin
    rst_n = 1'b0; fmt_sel = 1'b0; bit_clk = 1'b1; word_clk = 1'b0; smp_valid = 1'b0;
    smp_left = '0; smp_right = '0;
    for (int f = 0; f < 2; f++) begin
      set_len(32, 32, 32, 32, 32);    run(f * 10 + 0, f[0], 3);
      set_len(48, 48, 48, 48, 48);    run(f * 10 + 1, f[0], 3);
      set_len(64, 64, 64, 64, 64);    run(f * 10 + 2, f[0], 3);
      set_len(128, 128, 128, 128, 128); run(f * 10 + 3, f[0], 3);
      set_len(64, 32, 32, 64, 64);    run(f * 10 + 4, f[0], 5);
      set_len(32, 48, 32, 64, 32);    run(f * 10 + 5, f[0], 5);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule